// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) over a run of clock cycles. Only one adder of operand width and one double-width register are used. When a start request arrives while the unit is idle, it captures the multiplicand into its own register. At the same time it places the multiplier in the lower half of the double-width product register and clears the upper half.

In every busy cycle the unit inspects bit 0 of the product register. When that bit is set, it adds the multiplicand to the upper half. It then shifts the whole register, together with the carry of the add, one place to the right. The multiplier bits are consumed from the bottom while the partial product grows from the top. After `WIDTH` such cycles the register holds the full double-width product. The unit then raises a one-cycle completion pulse and returns to idle. The product stays on the output until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: During and directly after a synchronous active-high reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A start seen while idle is accepted at that clock edge. In the next cycle `busy_o` is 1, `product_o[2*WIDTH-1:WIDTH]` is 0 and `product_o[WIDTH-1:0]` equals the multiplier.
- R3: Each busy cycle tests bit 0 of the product register. If it is 1, the multiplicand is added to the upper half, and the carry is kept. The carry, sum and lower half are then shifted right by one bit as a single value. After the first iteration `product_o` equals `({0,multiplier} + (multiplier[0] ? multiplicand<<WIDTH : 0)) >> 1`.
- R4: `busy_o` stays 1 for exactly `WIDTH` consecutive cycles after an accepted start.
- R5: `done_o` is 1 for exactly one cycle, in the cycle directly after the last busy cycle, and is never 1 together with `busy_o`.
- R6: When `done_o` is 1, `product_o` equals the exact unsigned product of the captured operands. This includes all-ones operands, where the carry out of the adder is needed.
- R7: A start asserted while `busy_o` is 1 is ignored. It changes neither the operands in use, the cycle count nor the final product.
- R8: While idle and with no start, `product_o` holds its value unchanged.
- R9: A start asserted in the same cycle as `done_o` is accepted, so back-to-back multiplications are possible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a multiplication of the present operands |
| mcand_i | input | WIDTH | Multiplicand, captured on an accepted start |
| mplier_i | input | WIDTH | Multiplier, captured on an accepted start |
| busy_o | output | 1 | High while iterations are running |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2*WIDTH | Product register contents |

## Verification
The bench builds the block with `WIDTH = 32`, the default. At this width the all-ones corner is reachable, where every iteration adds and the adder carry lands in the top bit. The count of 32 iterations is also measured against a 5-bit counter that wraps exactly at its limit. Random operand pairs give mixed bit-0 patterns. Directed pairs cover zero operands, a single low bit, a single top bit, and the small 2 × 11 case. A start injected while busy and a start in the completion cycle exercise both sides of the acceptance rule.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic [0:0] {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import seq_mul_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e state_q;
  logic [CW-1:0] iter_q;
  logic done_q;

  assign load_o = start_i && (state_q == MUL_IDLE);
  assign step_o = (state_q == MUL_RUN);
  assign busy_o = (state_q == MUL_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MUL_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        MUL_IDLE: begin
          if (start_i) begin
            state_q <= MUL_RUN;
            iter_q  <= '0;
          end
        end
        MUL_RUN: begin
          if (iter_q == LAST) begin
            state_q <= MUL_IDLE;
            done_q  <= 1'b1;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end
        default: state_q <= MUL_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse, never overlapping busy
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    !(done_o && busy_o));
  // R4/R5: leaving the busy phase always raises completion
  assert_fall_done_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && iter_q == LAST) |=> (done_o && !busy_o));
  // R7: a start during a run does not end or restart the run
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && iter_q != LAST) |=> (busy_o && iter_q == $past(iter_q) + 1'b1));
endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   upper_sum;
  logic [WIDTH:0]   addend;
  logic [PW-1:0]    prod_next;

  // Only the upper half passes through the adder; the carry is the extra bit.
  assign addend    = prod_q[0] ? {1'b0, mcand_q} : '0;
  assign upper_sum = {1'b0, prod_q[PW-1:WIDTH]} + addend;
  assign prod_next = {upper_sum, prod_q[WIDTH-1:1]};
  assign prod_o    = prod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q <= prod_next;
    end
  end

  // R3: with bit 0 clear the register only shifts
  assert_shift_only_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && !prod_q[0]) |=> (prod_q == ($past(prod_q) >> 1)));
  // R3: the lower half always shifts down, add or not
  assert_low_shift_R3: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (prod_q[WIDTH-2:0] == $past(prod_q[WIDTH-1:1])));
  // R7: multiplicand is frozen while iterating
  assert_mcand_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    step_i |=> $stable(mcand_q));
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load;
  logic step;

  seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  seq_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (product_o)
  );

  // R2: an accepted start loads the multiplier low and clears the top
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && product_o[2*WIDTH-1:WIDTH] == '0
                              && product_o[WIDTH-1:0] == $past(mplier_i)));
  // R8: idle without start holds the product
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(product_o));
  // R9: a start during the completion cycle is taken
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> busy_o);
endmodule

// File: tb/test_seq_mul.sv
module test_seq_mul;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [W-1:0]   mcand;
  logic [W-1:0]   mplier;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seq_mul #(.WIDTH(W)) i_seq_mul (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (product)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] wa = {{W{1'b0}}, a};
    logic [2*W-1:0] wb = {{W{1'b0}}, b};
    return wa * wb;
  endfunction

  function automatic logic [2*W-1:0] ref_first(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W:0] t = {1'b0, {W{1'b0}}, b};
    if (b[0]) t = t + {1'b0, a, {W{1'b0}}};
    return t[2*W:1];
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(logic [W-1:0] a, logic [W-1:0] b);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    check("R2 loaded register", product, {{W{1'b0}}, b});
    @(negedge clk);
    check("R3 first iteration", product, ref_first(a, b));
  endtask

  // Returns at the negedge where done is seen; inject a start mid-run if asked.
  task automatic finish(logic [W-1:0] a, logic [W-1:0] b, bit inject);
    int busy_cycles = 2;
    while (!done && busy_cycles < 100) begin
      if (inject && busy_cycles == 6) begin
        start = 1'b1;
        mcand = ~a;
        mplier = b ^ 32'h5a5a_0f0f;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (!done) busy_cycles++;
    end
    start = 1'b0;
    check(inject ? "R7 cycle count with start while busy" : "R4 busy cycles",
          64'(busy_cycles), 64'(W));
    check("R5 done without busy", {62'd0, done, busy}, 64'd2);
    check(inject ? "R7 product unaffected" : "R6 product", product, ref_mul(a, b));
  endtask

  task automatic after_done(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    check("R5 done single cycle", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R8 product held while idle", product, ref_mul(a, b));
  endtask

  task automatic full(logic [W-1:0] a, logic [W-1:0] b);
    launch(a, b);
    finish(a, b, 1'b0);
    after_done(a, b);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {busy, done, product[61:0]}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {busy, done, product[61:0]}, 64'd0);
    check("R8 idle hold", product, 64'd0);

    full(32'd2, 32'd11);
    full(32'hffff_ffff, 32'hffff_ffff);
    full(32'd0, 32'hdead_beef);
    full(32'hcafe_f00d, 32'd0);
    full(32'h8000_0000, 32'h8000_0000);
    full(32'd1, 32'hffff_ffff);
    full(32'hffff_ffff, 32'd1);

    // R7: start during a run is ignored
    launch(32'h1234_5678, 32'h9abc_def1);
    finish(32'h1234_5678, 32'h9abc_def1, 1'b1);
    after_done(32'h1234_5678, 32'h9abc_def1);

    // R9: start in the done cycle
    launch(32'd7, 32'd9);
    finish(32'd7, 32'd9, 1'b0);
    check("R9 done seen before relaunch", {63'd0, done}, 64'd1);
    launch(32'hffff_0001, 32'h0001_ffff);
    finish(32'hffff_0001, 32'h0001_ffff, 1'b0);
    after_done(32'hffff_0001, 32'h0001_ffff);

    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a = $urandom;
      logic [W-1:0] b = $urandom;
      full(a, b);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule